// File: doc/BRIEF.md
# Test Access Port Controller with Five-Bit Instruction Decoder

This block is the serial test port of a programmable logic device. It is clocked by the test clock and runs the sixteen-state test port state machine. It holds a five-bit instruction and sends the serial test data through one of four data paths. Two of those paths are inside the block: the 32-bit identification register and the single-bit bypass stage. The other two are outside it: the boundary chain and the in-system programming signature register. The block selects them with select lines and reads their serial outputs back through two input pins.

The block also decodes the instruction into capture, shift and update strobes and into four output-mode flags. Pin-driving logic elsewhere uses the mode flags to choose between external test, internal test, high impedance and clamped outputs. The identification word is built from parameters. The low twelve bits hold a manufacturer code, and one parameter picks which of two codes is used. Above the code sit a three-bit package field, a thirteen-bit device field and a four-bit version field.

Top module: `scan_port_ctrl`

## Requirements
- R1: While `porN` is low, and after it is released, the state machine is in Test-Logic-Reset, the identification register is selected (`selIdcode`=1), `tdoOe` is 0 and all four mode flags are 0.
- R2: Five consecutive rising `tck` edges with `tms` high bring the state machine to Test-Logic-Reset from any state. In that state the instruction reverts to IDCODE (00001).
- R3: In Capture-IR the instruction shift stage loads 00001. Shifting it out gives the bits 1,0,0,0,0 on `tdo`, least significant bit first.
- R4: Selecting the identification register and scanning 32 bits returns {VERSION[3:0], DEVICE_ID[12:0], PACKAGE_ID[2:0], vendor[11:0]} least significant bit first. The vendor field is 12'h02B when VENDOR_ALT=0 and 12'h093 when VENDOR_ALT=1, so bit 0 is always 1.
- R5: The decoder asserts exactly one select line, as follows:
  - `selBoundary` for opcodes 00000, 00010, 00011 and 00100.
  - `selIdcode` for 00001.
  - `selIsp` for 00111 through 01100, 01110, 10000 and 10001.
  - `selBypass` for 00101, 00110, 01101, 11111 and every other code.
- R6: The bypass stage captures 0 and delays `tdi` by exactly one `tck` cycle.
- R7: During Shift-DR, `tdo` carries `bsrTdo` when the boundary chain is selected and `ispTdo` when the signature register is selected.
- R8: Each mode flag is 1 for exactly one opcode: `modeExtest` for 00000, `modeIntest` for 00011, `modeHighz` for 00101 and `modeClamp` for 00110. Any other opcode leaves all four flags at 0.
- R9: `tdo` and `tdoOe` change only on the falling edge of `tck`. `tdoOe` is 1 only while the state machine is in Shift-IR or Shift-DR.
- R10: Over one data register scan, `captureDr` is high for exactly one cycle, `updateDr` is high for exactly one cycle, and `shiftDr` is high for one cycle per shifted bit.
- R11: A new instruction takes effect in Update-IR, on the falling edge of `tck`. The select lines and the mode flags do not change during Shift-IR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| bsrTdo | input | 1 | Serial output of the external boundary chain |
| ispTdo | input | 1 | Serial output of the external signature register |
| tdo | output | 1 | Serial test data out (0 when not enabled) |
| tdoOe | output | 1 | Output enable for the test data pin |
| selBoundary | output | 1 | Boundary chain selected |
| selIdcode | output | 1 | Identification register selected |
| selBypass | output | 1 | Bypass stage selected |
| selIsp | output | 1 | Signature register selected |
| captureDr | output | 1 | Capture-DR strobe |
| shiftDr | output | 1 | Shift-DR strobe |
| updateDr | output | 1 | Update-DR strobe |
| modeExtest | output | 1 | External test output mode |
| modeIntest | output | 1 | Internal test output mode |
| modeHighz | output | 1 | All outputs high impedance |
| modeClamp | output | 1 | Outputs held from the boundary chain |

## Verification
Several properties are checked on every cycle:
- The select lines stay one-hot and at most one mode flag is raised.
- Five high `tms` edges always reach Test-Logic-Reset, and the IDCODE instruction follows there.
- `tdoOe` appears only in the shift states.
- The capture strobe lasts a single cycle, and shifting starts only after a capture or Exit2-DR.

The directed scenarios cover what needs known data: the captured instruction pattern, the full identification word, the one-cycle bypass delay, routing from the two external chains, and the complete opcode-to-select and opcode-to-mode mapping over all 32 codes.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;

  localparam int IR_W = 5;
  localparam int ID_W = 32;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAUSE_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAUSE_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {
    PATH_BOUNDARY, PATH_IDCODE, PATH_BYPASS, PATH_ISP
  } dr_path_e;

  typedef struct packed {
    logic testReset;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
  } strobe_t;

  localparam logic [IR_W-1:0] OP_EXTEST = 5'b00000;
  localparam logic [IR_W-1:0] OP_IDCODE = 5'b00001;
  localparam logic [IR_W-1:0] OP_INTEST = 5'b00011;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 5'b00101;
  localparam logic [IR_W-1:0] OP_CLAMP  = 5'b00110;

  function automatic dr_path_e decodePath(input logic [IR_W-1:0] op);
    case (op)
      5'b00000, 5'b00010, 5'b00011, 5'b00100: decodePath = PATH_BOUNDARY;
      5'b00001:                               decodePath = PATH_IDCODE;
      5'b00111, 5'b01000, 5'b01001, 5'b01010,
      5'b01011, 5'b01100, 5'b01110, 5'b10000,
      5'b10001:                               decodePath = PATH_ISP;
      default:                                decodePath = PATH_BYPASS;
    endcase
  endfunction

endpackage

// File: rtl/scan_port_fsm.sv
module scan_port_fsm
  import scan_port_pkg::*;
(
  input  logic       tck,
  input  logic       porN,
  input  logic       tms,
  output tap_state_e state,
  output strobe_t    stb,
  output logic       updateDr
);

  tap_state_e nextState;

  always_comb begin
    case (state)
      ST_RESET:    nextState = tms ? ST_RESET    : ST_IDLE;
      ST_IDLE:     nextState = tms ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_DR:   nextState = tms ? ST_SEL_IR   : ST_CAP_DR;
      ST_CAP_DR:   nextState = tms ? ST_EX1_DR   : ST_SH_DR;
      ST_SH_DR:    nextState = tms ? ST_EX1_DR   : ST_SH_DR;
      ST_EX1_DR:   nextState = tms ? ST_UPD_DR   : ST_PAUSE_DR;
      ST_PAUSE_DR: nextState = tms ? ST_EX2_DR   : ST_PAUSE_DR;
      ST_EX2_DR:   nextState = tms ? ST_UPD_DR   : ST_SH_DR;
      ST_UPD_DR:   nextState = tms ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_IR:   nextState = tms ? ST_RESET    : ST_CAP_IR;
      ST_CAP_IR:   nextState = tms ? ST_EX1_IR   : ST_SH_IR;
      ST_SH_IR:    nextState = tms ? ST_EX1_IR   : ST_SH_IR;
      ST_EX1_IR:   nextState = tms ? ST_UPD_IR   : ST_PAUSE_IR;
      ST_PAUSE_IR: nextState = tms ? ST_EX2_IR   : ST_PAUSE_IR;
      ST_EX2_IR:   nextState = tms ? ST_UPD_IR   : ST_SH_IR;
      ST_UPD_IR:   nextState = tms ? ST_SEL_DR   : ST_IDLE;
      default:     nextState = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge porN) begin
    if (!porN) state <= ST_RESET;
    else       state <= nextState;
  end

  always_comb begin
    stb.testReset = (state == ST_RESET);
    stb.captureIr = (state == ST_CAP_IR);
    stb.shiftIr   = (state == ST_SH_IR);
    stb.updateIr  = (state == ST_UPD_IR);
    stb.captureDr = (state == ST_CAP_DR);
    stb.shiftDr   = (state == ST_SH_DR);
    updateDr      = (state == ST_UPD_DR);
  end

endmodule

// File: rtl/scan_port_path.sv
module scan_port_path
  import scan_port_pkg::*;
#(
  parameter bit          VENDOR_ALT = 1'b0,
  parameter logic [12:0] DEVICE_ID  = 13'h0A51,
  parameter logic [2:0]  PACKAGE_ID = 3'h5,
  parameter logic [3:0]  VERSION    = 4'h3
) (
  input  logic    tck,
  input  logic    porN,
  input  logic    tdi,
  input  strobe_t stb,
  input  logic    bsrTdo,
  input  logic    ispTdo,
  output logic    tdo,
  output logic    tdoOe,
  output logic    selBoundary,
  output logic    selIdcode,
  output logic    selBypass,
  output logic    selIsp,
  output logic    modeExtest,
  output logic    modeIntest,
  output logic    modeHighz,
  output logic    modeClamp
);

  localparam logic [11:0] VENDOR_CODE = VENDOR_ALT ? 12'h093 : 12'h02B;
  localparam logic [ID_W-1:0] ID_WORD =
    {VERSION, DEVICE_ID, PACKAGE_ID, VENDOR_CODE[11:1], 1'b1};

  logic [IR_W-1:0] irShift;
  logic [IR_W-1:0] irHeld;
  logic [ID_W-1:0] idShift;
  logic            bypassBit;
  logic            tdoQ;
  logic            oeQ;
  dr_path_e        path;

  assign path = decodePath(irHeld);

  // Instruction shift stage: capture fixed pattern, shift LSB out
  always_ff @(posedge tck or negedge porN) begin
    if (!porN)              irShift <= OP_IDCODE;
    else if (stb.captureIr) irShift <= OP_IDCODE;
    else if (stb.shiftIr)   irShift <= {tdi, irShift[IR_W-1:1]};
  end

  // Active instruction changes on the falling edge only
  always_ff @(negedge tck or negedge porN) begin
    if (!porN)              irHeld <= OP_IDCODE;
    else if (stb.testReset) irHeld <= OP_IDCODE;
    else if (stb.updateIr)  irHeld <= irShift;
  end

  always_ff @(posedge tck or negedge porN) begin
    if (!porN) begin
      idShift   <= '0;
      bypassBit <= 1'b0;
    end else begin
      if (path == PATH_IDCODE) begin
        if (stb.captureDr)    idShift <= ID_WORD;
        else if (stb.shiftDr) idShift <= {tdi, idShift[ID_W-1:1]};
      end
      if (path == PATH_BYPASS) begin
        if (stb.captureDr)    bypassBit <= 1'b0;
        else if (stb.shiftDr) bypassBit <= tdi;
      end
    end
  end

  always_ff @(negedge tck or negedge porN) begin
    if (!porN) begin
      tdoQ <= 1'b0;
      oeQ  <= 1'b0;
    end else begin
      oeQ <= stb.shiftIr | stb.shiftDr;
      if (stb.shiftIr) tdoQ <= irShift[0];
      else if (stb.shiftDr) begin
        case (path)
          PATH_BOUNDARY: tdoQ <= bsrTdo;
          PATH_IDCODE:   tdoQ <= idShift[0];
          PATH_ISP:      tdoQ <= ispTdo;
          default:       tdoQ <= bypassBit;
        endcase
      end
    end
  end

  assign tdo         = tdoQ & oeQ;
  assign tdoOe       = oeQ;
  assign selBoundary = (path == PATH_BOUNDARY);
  assign selIdcode   = (path == PATH_IDCODE);
  assign selBypass   = (path == PATH_BYPASS);
  assign selIsp      = (path == PATH_ISP);
  assign modeExtest  = (irHeld == OP_EXTEST);
  assign modeIntest  = (irHeld == OP_INTEST);
  assign modeHighz   = (irHeld == OP_HIGHZ);
  assign modeClamp   = (irHeld == OP_CLAMP);

endmodule

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
  import scan_port_pkg::*;
#(
  parameter bit          VENDOR_ALT = 1'b0,
  parameter logic [12:0] DEVICE_ID  = 13'h0A51,
  parameter logic [2:0]  PACKAGE_ID = 3'h5,
  parameter logic [3:0]  VERSION    = 4'h3
) (
  input  logic tck,
  input  logic porN,
  input  logic tms,
  input  logic tdi,
  input  logic bsrTdo,
  input  logic ispTdo,
  output logic tdo,
  output logic tdoOe,
  output logic selBoundary,
  output logic selIdcode,
  output logic selBypass,
  output logic selIsp,
  output logic captureDr,
  output logic shiftDr,
  output logic updateDr,
  output logic modeExtest,
  output logic modeIntest,
  output logic modeHighz,
  output logic modeClamp
);

  tap_state_e state;
  strobe_t    stb;

  scan_port_fsm u_ctl (
    .tck(tck), .porN(porN), .tms(tms),
    .state(state), .stb(stb), .updateDr(updateDr)
  );

  scan_port_path #(
    .VENDOR_ALT(VENDOR_ALT), .DEVICE_ID(DEVICE_ID),
    .PACKAGE_ID(PACKAGE_ID), .VERSION(VERSION)
  ) u_dp (
    .tck(tck), .porN(porN), .tdi(tdi), .stb(stb),
    .bsrTdo(bsrTdo), .ispTdo(ispTdo),
    .tdo(tdo), .tdoOe(tdoOe),
    .selBoundary(selBoundary), .selIdcode(selIdcode),
    .selBypass(selBypass), .selIsp(selIsp),
    .modeExtest(modeExtest), .modeIntest(modeIntest),
    .modeHighz(modeHighz), .modeClamp(modeClamp)
  );

  assign captureDr = stb.captureDr;
  assign shiftDr   = stb.shiftDr;

endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
  import scan_port_pkg::*;
(
  input logic       tck,
  input logic       porN,
  input logic       tms,
  input tap_state_e state,
  input logic       tdoOe,
  input logic       selBoundary,
  input logic       selIdcode,
  input logic       selBypass,
  input logic       selIsp,
  input logic       captureDr,
  input logic       shiftDr,
  input logic       modeExtest,
  input logic       modeIntest,
  input logic       modeHighz,
  input logic       modeClamp
);

  logic [2:0] tmsRun;

  always_ff @(posedge tck or negedge porN) begin
    if (!porN)         tmsRun <= '0;
    else if (!tms)     tmsRun <= '0;
    else if (tmsRun != 3'd7) tmsRun <= tmsRun + 3'd1;
  end

  assert_sel_onehot_R5: assert property (@(posedge tck) disable iff (!porN)
    $onehot({selBoundary, selIdcode, selBypass, selIsp}));

  assert_mode_excl_R8: assert property (@(posedge tck) disable iff (!porN)
    $onehot0({modeExtest, modeIntest, modeHighz, modeClamp}));

  assert_tms_reset_R2: assert property (@(posedge tck) disable iff (!porN)
    (tmsRun >= 3'd5) |-> (state == ST_RESET));

  assert_reset_idcode_R2: assert property (@(posedge tck) disable iff (!porN)
    (state == ST_RESET && $past(state) == ST_RESET) |-> selIdcode);

  assert_oe_shift_R9: assert property (@(posedge tck) disable iff (!porN)
    tdoOe |-> (state == ST_SH_DR || state == ST_SH_IR));

  assert_capture_single_R10: assert property (@(posedge tck) disable iff (!porN)
    captureDr |=> !captureDr);

  assert_shift_entry_R10: assert property (@(posedge tck) disable iff (!porN)
    $rose(shiftDr) |-> ($past(captureDr) || $past(state) == ST_EX2_DR));

  assert_ir_hold_R11: assert property (@(posedge tck) disable iff (!porN)
    (state == ST_SH_IR && $past(state) == ST_SH_IR) |->
      ($stable({selBoundary, selIdcode, selBypass, selIsp}) &&
       $stable({modeExtest, modeIntest, modeHighz, modeClamp})));

endmodule

bind scan_port_ctrl scan_port_chk u_chk (
  .tck(tck), .porN(porN), .tms(tms), .state(u_ctl.state), .tdoOe(tdoOe),
  .selBoundary(selBoundary), .selIdcode(selIdcode),
  .selBypass(selBypass), .selIsp(selIsp),
  .captureDr(captureDr), .shiftDr(shiftDr),
  .modeExtest(modeExtest), .modeIntest(modeIntest),
  .modeHighz(modeHighz), .modeClamp(modeClamp)
);

// File: tb/sim_scan_port_ctrl.sv
`timescale 1ns/1ps
module sim_scan_port_ctrl;

  logic tck = 1'b0;
  logic porN = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic bsrTdo = 1'b0;
  logic ispTdo = 1'b0;
  logic tdo, tdoOe, selBoundary, selIdcode, selBypass, selIsp;
  logic captureDr, shiftDr, updateDr;
  logic modeExtest, modeIntest, modeHighz, modeClamp;

  int checks = 0;
  int errors = 0;
  int capCnt, shCnt, updCnt;
  logic sTdo, sOe;

  always #4 tck = ~tck;

  scan_port_ctrl u0 (
    .tck(tck), .porN(porN), .tms(tms), .tdi(tdi),
    .bsrTdo(bsrTdo), .ispTdo(ispTdo), .tdo(tdo), .tdoOe(tdoOe),
    .selBoundary(selBoundary), .selIdcode(selIdcode),
    .selBypass(selBypass), .selIsp(selIsp),
    .captureDr(captureDr), .shiftDr(shiftDr), .updateDr(updateDr),
    .modeExtest(modeExtest), .modeIntest(modeIntest),
    .modeHighz(modeHighz), .modeClamp(modeClamp)
  );

  localparam logic [31:0] EXP_ID = {4'h3, 13'h0A51, 3'h5, 12'h02B};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // inputs change after the falling edge; outputs sampled just after the rising edge
  task automatic step(input logic m, input logic d);
    @(negedge tck); #1;
    tms = m; tdi = d;
    @(posedge tck); #1;
    sTdo = tdo; sOe = tdoOe;
    if (captureDr) capCnt++;
    if (shiftDr)   shCnt++;
    if (updateDr)  updCnt++;
  endtask

  task automatic goIdle();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic loadIr(input logic [4:0] op, output logic [4:0] cap);
    logic [3:0] selBefore;
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    selBefore = {selBoundary, selIdcode, selBypass, selIsp};
    for (int i = 0; i < 5; i++) begin
      step(i == 4, op[i]);
      cap[i] = sTdo;
    end
    check("R11 select held during IR shift",
          {60'd0, selBoundary, selIdcode, selBypass, selIsp}, {60'd0, selBefore});
    step(1'b1, 1'b0); step(1'b0, 1'b0);
  endtask

  task automatic scanDr(input int n, input logic [63:0] din, output logic [63:0] dout,
                        output int oeLow);
    dout = '0; oeLow = 0; capCnt = 0; shCnt = 0; updCnt = 0;
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]);
      dout[i] = sTdo;
      if (!sOe) oeLow++;
    end
    step(1'b1, 1'b0); step(1'b0, 1'b0);
  endtask

  function automatic logic [3:0] expSel(input logic [4:0] op);
    case (op)
      5'd1: return 4'b0100;
      5'd0, 5'd2, 5'd3, 5'd4: return 4'b1000;
      5'd7, 5'd8, 5'd9, 5'd10, 5'd11, 5'd12, 5'd14, 5'd16, 5'd17: return 4'b0001;
      default: return 4'b0010;
    endcase
  endfunction

  function automatic logic [3:0] expMode(input logic [4:0] op);
    case (op)
      5'd0: return 4'b1000;
      5'd3: return 4'b0100;
      5'd5: return 4'b0010;
      5'd6: return 4'b0001;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic testReset();
    check("R1 selIdcode in reset", {63'd0, selIdcode}, 64'd1);
    check("R1 tdoOe in reset", {63'd0, tdoOe}, 64'd0);
    check("R1 modes in reset",
          {60'd0, modeExtest, modeIntest, modeHighz, modeClamp}, 64'd0);
    porN = 1'b1;
    step(1'b1, 1'b0);
    check("R1 selIdcode after release", {63'd0, selIdcode}, 64'd1);
    step(1'b0, 1'b0);
  endtask

  task automatic testIdcode();
    logic [63:0] d; int lo;
    scanDr(32, 64'd0, d, lo);
    check("R4 idcode word", d, {32'd0, EXP_ID});
    check("R4 idcode bit0", {63'd0, d[0]}, 64'd1);
    check("R9 oe during shift", lo, 0);
    check("R9 oe after scan", {63'd0, tdoOe}, 64'd0);
    check("R10 captureDr count", capCnt, 1);
    check("R10 shiftDr count", shCnt, 32);
    check("R10 updateDr count", updCnt, 1);
  endtask

  task automatic testCaptureIr();
    logic [4:0] c;
    loadIr(5'b11111, c);
    check("R3 captured IR pattern", {59'd0, c}, {59'd0, 5'b00001});
    check("R5 bypass after load", {63'd0, selBypass}, 64'd1);
  endtask

  task automatic testBypass();
    logic [63:0] d; int lo;
    logic [7:0] p = 8'b1011_0010;
    scanDr(8, {56'd0, p}, d, lo);
    check("R6 bypass one-cycle delay", d, {55'd0, p[6:0], 1'b0});
  endtask

  task automatic testRouting();
    logic [63:0] d; int lo; logic [4:0] c;
    loadIr(5'b01011, c);
    check("R5 program opcode selects isp", {63'd0, selIsp}, 64'd1);
    ispTdo = 1'b1; bsrTdo = 1'b0;
    scanDr(4, 64'd0, d, lo);
    check("R7 isp routed", d, 64'hF);
    loadIr(5'b00000, c);
    check("R8 extest flag", {63'd0, modeExtest}, 64'd1);
    ispTdo = 1'b0; bsrTdo = 1'b1;
    scanDr(4, 64'd0, d, lo);
    check("R7 boundary routed", d, 64'hF);
    bsrTdo = 1'b0;
  endtask

  task automatic testDecodeAll();
    logic [4:0] c;
    for (int op = 0; op < 32; op++) begin
      loadIr(op[4:0], c);
      check($sformatf("R5 select op %0d", op),
            {60'd0, selBoundary, selIdcode, selBypass, selIsp}, {60'd0, expSel(op[4:0])});
      check($sformatf("R8 mode op %0d", op),
            {60'd0, modeExtest, modeIntest, modeHighz, modeClamp}, {60'd0, expMode(op[4:0])});
    end
  endtask

  task automatic testTmsReset();
    logic [4:0] c;
    loadIr(5'b00110, c);
    check("R8 clamp flag", {63'd0, modeClamp}, 64'd1);
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    check("R2 idcode after five tms high", {63'd0, selIdcode}, 64'd1);
    check("R2 clamp cleared", {63'd0, modeClamp}, 64'd0);
    step(1'b0, 1'b0);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #20;
    testReset();
    testIdcode();
    testCaptureIr();
    testBypass();
    testRouting();
    testDecodeAll();
    testTmsReset();
    goIdle();
    testIdcode();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule